// File: doc/BRIEF.md
# No-Wait-State Pipelined Synchronous SRAM

This block is a clocked single-port memory whose bus can turn from a read to a write, or from a write to a read, on consecutive cycles. No idle cycles are needed between them. Every command input is registered on the rising clock edge. A command carries an address, a direction and the three chip selects. Its data phase comes two enabled cycles later. For a read, that is when the word appears on `rd_data` with `rd_oe` high. For a write, that is when `wr_data` and the byte-write strobes are sampled. Reads and writes share the same latency, so any mix of commands keeps the bus fully used.

Each cycle, the `adv` input chooses between two actions. It either loads a new external address, which starts a read, a write or a deselect, or it steps a two-bit burst counter inside the current burst. The burst order is linear or interleaved, chosen by `burst_ilv`. While the active-low clock enable is high, the whole block is frozen: all pipeline stages, the burst state and the outputs keep their values.

Top module: `nowait_sram`

## Requirements
- R1: Any sequence of reads and writes, one per enabled cycle, runs with no idle cycle between them. Every read returns the most recent data written to its address.
- R2: Read data appears on `rd_data` with `rd_oe` high after the second enabled rising edge that follows the edge which registered the read command. Write data and strobes are sampled on the second enabled edge after the write command.
- R3: A read issued on the cycle right after a write to the same address returns the newly written word.
- R4: While `cke_n` is 1, all other inputs are ignored. `rd_data`, `rd_oe`, the pipeline and the burst state hold. Operation resumes exactly where it stopped.
- R5: With `adv` = 0 on an enabled edge, `addr` is loaded and a new command starts: a write if `we_n` = 0, a read if `we_n` = 1.
- R6: With `adv` = 1 on an enabled edge, the burst counter steps. The new command keeps the direction and selection of the command that opened the burst, and `we_n` and the chip selects are ignored.
- R7: With `burst_ilv` = 0, the two low address bits of successive burst beats are base+1, base+2, base+3, wrapping modulo 4. The upper bits stay those of the base address.
- R8: With `burst_ilv` = 1, the two low address bits of beat k (k = 0..3) are the base's low bits XOR k.
- R9: A load is selected only when `ce1_n` = 0, `ce2` = 1 and `ce3_n` = 0. Any other combination is a deselect: no memory write takes place and `rd_oe` stays 0 in its data cycle.
- R10: During a write data phase, `bw_n[i]` = 0 writes byte i, which is `wr_data[9*i+8:9*i]`. A byte whose strobe is 1 keeps its previous contents.
- R11: `rd_oe` is 1 only in the cycle in which read data is presented. It is 0 in the data cycles of writes and deselects.
- R12: After reset, `rd_oe` = 0, `rd_data` = 0 and no burst is open, so `adv` = 1 before the first load gives a deselect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_n | input | 1 | Active-low clock enable; 1 freezes the block |
| adv | input | 1 | 0 loads a new address, 1 steps the burst |
| we_n | input | 1 | Direction at load: 0 write, 1 read |
| ce1_n | input | 1 | Chip select, active low |
| ce2 | input | 1 | Chip select, active high |
| ce3_n | input | 1 | Chip select, active low |
| burst_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| addr | input | ADDR_W | Word address, sampled at load |
| bw_n | input | NBYTES | Active-low byte-write strobes, sampled in the write data phase |
| wr_data | input | NBYTES*BYTE_W | Write data, sampled in the write data phase |
| rd_data | output | NBYTES*BYTE_W | Registered read data |
| rd_oe | output | 1 | High in the cycle read data is presented |

## Verification
The checker watches these properties on every cycle:
- the freeze holds the outputs while the clock enable is high;
- `rd_oe` follows the operation held in the last pipeline stage;
- a deselecting chip-select pattern yields an idle command;
- a continued beat inherits its burst's operation;
- linear bursts step their low address bits by one.

Only the bench's scenarios can show some behaviours, because they depend on the stored data:
- the returned data itself;
- read-after-write on the next cycle;
- byte masking;
- interleaved ordering;
- the fact that a deselected write leaves memory untouched.

// File: rtl/nws_pkg.sv
package nws_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // low two address bits of a burst beat
    function automatic logic [1:0] beat_low(input logic [1:0] base_lo,
                                            input logic [1:0] step,
                                            input logic       interleave);
        return interleave ? (base_lo ^ step) : 2'(base_lo + step);
    endfunction

endpackage

// File: rtl/nws_burst_gen.sv
module nws_burst_gen
    import nws_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              adv,
    input  logic              interleave,
    input  logic              we_n,
    input  logic              selected,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic [ADDR_W-1:0] base_q,
    input  logic [1:0]        cnt_q,
    input  op_e               op_q,
    output logic [ADDR_W-1:0] base_d,
    output logic [1:0]        cnt_d,
    output op_e               op_d,
    output logic [ADDR_W-1:0] beat_addr
);

    always_comb begin
        if (!adv) begin
            base_d    = ext_addr;
            cnt_d     = 2'd0;
            op_d      = !selected ? OP_IDLE : (we_n ? OP_READ : OP_WRITE);
            beat_addr = ext_addr;
        end else begin
            base_d    = base_q;
            cnt_d     = 2'(cnt_q + 2'd1);
            op_d      = op_q;
            beat_addr = {base_q[ADDR_W-1:2], beat_low(base_q[1:0], cnt_d, interleave)};
        end
    end

endmodule

// File: rtl/nws_mem_array.sv
module nws_mem_array #(
    parameter int ADDR_W = 6,
    parameter int NBYTES = 4,
    parameter int BYTE_W = 9
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [NBYTES-1:0]        bw_n,
    input  logic [NBYTES*BYTE_W-1:0] wdata,
    output logic [NBYTES*BYTE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        logic [BYTE_W-1:0] lane [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && !bw_n[b]) begin
                lane[addr] <= wdata[b*BYTE_W +: BYTE_W];
            end
        end

        assign rdata[b*BYTE_W +: BYTE_W] = lane[addr];
    end

endmodule

// File: rtl/nowait_sram.sv
module nowait_sram
    import nws_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NBYTES = 4,
    parameter int BYTE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cke_n,
    input  logic                     adv,
    input  logic                     we_n,
    input  logic                     ce1_n,
    input  logic                     ce2,
    input  logic                     ce3_n,
    input  logic                     burst_ilv,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [NBYTES-1:0]        bw_n,
    input  logic [NBYTES*BYTE_W-1:0] wr_data,
    output logic [NBYTES*BYTE_W-1:0] rd_data,
    output logic                     rd_oe
);

    localparam int DATA_W = NBYTES * BYTE_W;

    typedef struct packed {
        op_e              op;
        logic [ADDR_W-1:0] addr;
    } stage_t;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [1:0]        cnt;
        op_e               bop;
        stage_t            s1;
        stage_t            s2;
        logic              oe;
        logic [DATA_W-1:0] rdata;
    } state_t;

    state_t q, d;

    logic              sel;
    logic [ADDR_W-1:0] base_n;
    logic [1:0]        cnt_n;
    op_e               op_n;
    logic [ADDR_W-1:0] beat_addr;
    logic              mem_we;
    logic [DATA_W-1:0] mem_rd;

    assign sel = !ce1_n && ce2 && !ce3_n;

    nws_burst_gen #(.ADDR_W(ADDR_W)) u_burst (
        .adv        (adv),
        .interleave (burst_ilv),
        .we_n       (we_n),
        .selected   (sel),
        .ext_addr   (addr),
        .base_q     (q.base),
        .cnt_q      (q.cnt),
        .op_q       (q.bop),
        .base_d     (base_n),
        .cnt_d      (cnt_n),
        .op_d       (op_n),
        .beat_addr  (beat_addr)
    );

    nws_mem_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_mem (
        .clk   (clk),
        .wr_en (mem_we),
        .addr  (q.s2.addr),
        .bw_n  (bw_n),
        .wdata (wr_data),
        .rdata (mem_rd)
    );

    always_comb begin
        d      = q;
        mem_we = 1'b0;
        if (!cke_n) begin
            d.base    = base_n;
            d.cnt     = cnt_n;
            d.bop     = op_n;
            d.s1.op   = op_n;
            d.s1.addr = beat_addr;
            d.s2      = q.s1;
            d.oe      = (q.s2.op == OP_READ);
            if (q.s2.op == OP_READ) begin
                d.rdata = mem_rd;
            end
            mem_we = (q.s2.op == OP_WRITE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rd_data = q.rdata;
    assign rd_oe   = q.oe;

endmodule

// File: rtl/nowait_sram_chk.sv
module nowait_sram_chk #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke_n,
    input logic              adv,
    input logic              burst_ilv,
    input logic              ce1_n,
    input logic              ce2,
    input logic              ce3_n,
    input logic              rd_oe,
    input logic [DATA_W-1:0] rd_data,
    input logic [1:0]        s1_op,
    input logic [ADDR_W-1:0] s1_addr,
    input logic [1:0]        s2_op,
    input logic [1:0]        bop
);

    // R4
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> ($stable(rd_oe) && $stable(rd_data)));

    // R11
    oe_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && s2_op == 2'd1) |=> rd_oe);

    // R11
    oe_off_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && s2_op != 2'd1) |=> !rd_oe);

    // R9
    deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !adv && (ce1_n || !ce2 || ce3_n)) |=> (s1_op == 2'd0));

    // R6
    burst_inherit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && adv) |=> (s1_op == $past(bop)));

    // R7
    linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && adv && !burst_ilv) |=> (s1_addr[1:0] == 2'($past(s1_addr[1:0]) + 2'd1)));

endmodule

bind nowait_sram nowait_sram_chk #(.ADDR_W(ADDR_W), .DATA_W(NBYTES*BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke_n     (cke_n),
    .adv       (adv),
    .burst_ilv (burst_ilv),
    .ce1_n     (ce1_n),
    .ce2       (ce2),
    .ce3_n     (ce3_n),
    .rd_oe     (rd_oe),
    .rd_data   (rd_data),
    .s1_op     (q.s1.op),
    .s1_addr   (q.s1.addr),
    .s2_op     (q.s2.op),
    .bop       (q.bop)
);

// File: tb/nowait_sram_tb.sv
module nowait_sram_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 6;
    localparam int NBYTES = 4;
    localparam int BYTE_W = 9;
    localparam int DATA_W = NBYTES * BYTE_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cke_n = 1'b0, adv = 1'b0, we_n = 1'b1;
    logic              ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1, burst_ilv = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [NBYTES-1:0] bw_n = '1;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic              rd_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    nowait_sram #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .adv(adv), .we_n(we_n),
        .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .burst_ilv(burst_ilv),
        .addr(addr), .bw_n(bw_n), .wr_data(wr_data),
        .rd_data(rd_data), .rd_oe(rd_oe)
    );

    typedef struct {
        int                op;   // 0 idle, 1 read, 2 write
        logic [ADDR_W-1:0] a;
        logic [NBYTES-1:0] bw;
        logic [DATA_W-1:0] wd;
    } cmd_t;

    int tests = 0;
    int fails = 0;

    logic [DATA_W-1:0] model [DEPTH];
    cmd_t p1, p2;
    logic [ADDR_W-1:0] b_base;
    logic [1:0]        b_cnt;
    int                b_op;
    logic [DATA_W-1:0] exp_rd;
    logic              exp_oe;
    string             exp_tag;

    function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old,
                                                input logic [DATA_W-1:0] nw,
                                                input logic [NBYTES-1:0] strobe_n);
        logic [DATA_W-1:0] r = old;
        for (int i = 0; i < NBYTES; i++)
            if (!strobe_n[i]) r[i*BYTE_W +: BYTE_W] = nw[i*BYTE_W +: BYTE_W];
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] rnd_word();
        return {$urandom(), $urandom()} ;
    endfunction

    task automatic check_outputs();
        tests++;
        if (rd_oe !== exp_oe) begin
            fails++;
            $display("FAIL %s: rd_oe=%0b expected %0b", exp_tag, rd_oe, exp_oe);
        end
        tests++;
        if (rd_data !== exp_rd) begin
            fails++;
            $display("FAIL %s: rd_data=%h expected %h", exp_tag, rd_data, exp_rd);
        end
    endtask

    // one bus cycle, entered and left at a falling edge
    task automatic step(input string tag, input bit frz, input bit a, input bit wn,
                        input bit sel, input bit md, input logic [ADDR_W-1:0] ad,
                        input logic [NBYTES-1:0] bw);
        cmd_t c;
        check_outputs();
        cke_n = frz; adv = a; we_n = wn; burst_ilv = md; addr = ad;
        if (sel) begin
            ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
        end else begin
            case ($urandom_range(2))
                0: begin ce1_n = 1'b1; ce2 = 1'b1; ce3_n = 1'b0; end
                1: begin ce1_n = 1'b0; ce2 = 1'b0; ce3_n = 1'b0; end
                default: begin ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b1; end
            endcase
        end
        if (frz) begin
            wr_data = rnd_word();
            bw_n    = 4'($urandom());
        end else begin
            if (!a) begin
                b_base = ad; b_cnt = 2'd0;
                b_op   = sel ? (wn ? 1 : 2) : 0;
                c.a    = ad;
            end else begin
                b_cnt = 2'(b_cnt + 2'd1);
                c.a   = {b_base[ADDR_W-1:2],
                         md ? (b_base[1:0] ^ b_cnt) : 2'(b_base[1:0] + b_cnt)};
            end
            c.op = b_op; c.bw = bw; c.wd = rnd_word();
            if (p2.op == 2) begin
                wr_data = p2.wd; bw_n = p2.bw;
                model[p2.a] = merge(model[p2.a], p2.wd, p2.bw);
                exp_oe = 1'b0;
            end else begin
                wr_data = rnd_word(); bw_n = 4'($urandom());
                exp_oe = (p2.op == 1);
                if (p2.op == 1) exp_rd = model[p2.a];
            end
            exp_tag = tag;
            p2 = p1; p1 = c;
        end
        @(negedge clk);
    endtask

    task automatic idle(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag, 0, 0, 1, 0, 0, '0, '1);
    endtask

    initial begin
        p1 = '{0, '0, '1, '0}; p2 = p1;
        b_base = '0; b_cnt = 2'd0; b_op = 0;
        exp_rd = '0; exp_oe = 1'b0; exp_tag = "R12";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state, then a continue before any load is a deselect
        step("R12", 0, 1, 0, 1, 0, 6'd5, '0);
        idle("R12", 3);
        // R5: fill every word with single writes
        for (int i = 0; i < DEPTH; i++) step("R5", 0, 0, 0, 1, 0, 6'(i), '0);
        idle("R5", 2);
        // R2: lone read, data two enabled cycles later
        step("R2", 0, 0, 1, 1, 0, 6'd9, '1);
        idle("R2", 3);
        // R3: write then read same address back to back
        step("R3", 0, 0, 0, 1, 0, 6'd12, '0);
        step("R3", 0, 0, 1, 1, 0, 6'd12, '1);
        idle("R3", 3);
        // R10: partial byte writes
        step("R10", 0, 0, 0, 1, 0, 6'd20, 4'b1010);
        step("R10", 0, 0, 0, 1, 0, 6'd21, 4'b0111);
        step("R10", 0, 0, 1, 1, 0, 6'd20, '1);
        step("R10", 0, 0, 1, 1, 0, 6'd21, '1);
        idle("R10", 3);
        // R9: deselected write must not change memory
        step("R9", 0, 0, 0, 0, 0, 6'd30, '0);
        step("R9", 0, 0, 1, 0, 0, 6'd30, '1);
        step("R9", 0, 0, 1, 1, 0, 6'd30, '1);
        idle("R9", 3);
        // R7: linear read burst from low bits 2, wraps
        step("R7", 0, 0, 1, 1, 0, 6'd42, '1);
        for (int i = 0; i < 3; i++) step("R7", 0, 1, 0, 0, 0, 6'd0, '1);
        idle("R7", 3);
        // R8: interleaved read burst from low bits 1
        step("R8", 0, 0, 1, 1, 1, 6'd49, '1);
        for (int i = 0; i < 3; i++) step("R8", 0, 1, 0, 0, 1, 6'd0, '1);
        idle("R8", 3);
        // R6: write burst with we_n and selects wiggling on continues
        step("R6", 0, 0, 0, 1, 0, 6'd56, '0);
        for (int i = 0; i < 3; i++) step("R6", 0, 1, 1, 0, 0, 6'd3, '0);
        step("R6", 0, 0, 1, 1, 0, 6'd56, '1);
        for (int i = 0; i < 3; i++) step("R6", 0, 1, 0, 1, 0, 6'd3, '1);
        idle("R6", 3);
        // R4: freeze mid read burst
        step("R4", 0, 0, 1, 1, 0, 6'd60, '1);
        step("R4", 0, 1, 1, 1, 0, 6'd0, '1);
        for (int i = 0; i < 4; i++) step("R4", 1, $urandom_range(1), 0, 1, 0, 6'($urandom()), '0);
        step("R4", 0, 1, 1, 1, 0, 6'd0, '1);
        for (int i = 0; i < 3; i++) step("R4", 1, 0, 0, 1, 1, 6'($urandom()), '0);
        idle("R4", 3);
        // R1: constrained random mixed traffic
        begin
            bit md = 1'b0;
            void'($urandom(32'h5eed_1234));
            for (int i = 0; i < 600; i++) begin
                bit frz = ($urandom_range(7) == 0);
                bit a   = ($urandom_range(1) == 1);
                if (!frz && !a) md = $urandom_range(1);
                step("R1", frz, a, $urandom_range(1), $urandom_range(9) != 0, md,
                     6'($urandom()), 4'($urandom()));
            end
        end
        idle("R1", 4);
        check_outputs();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule